// File: doc/BRIEF.md
# Serial Word FIFO Packer

This block sits between a 32-bit register bus and a serial shift engine. Software fills a transmit queue with 32-bit entries. The engine takes serial words from the head of that queue one at a time. In the other direction, the engine deposits received words into a receive queue, and software drains that queue over the bus. A serial word is 1, 2 or 4 bytes wide, depending on the programmed word length.

Transmit words come from the most significant end of a queue entry. Received words are stored right-justified. For each direction the block counts transferred words against a programmed limit. It keeps live fill status and sticky service/done flags, and it records overrun and underrun errors. Sticky bits are cleared by writing ones to them. A single interrupt line goes high when an error is pending or an unmasked service or done flag is set.

Queue geometry comes from two small codes. A 2-bit block code selects the block size: 4 words for code 0, otherwise code × 16 words. A 3-bit depth code sets the queue depth to block × (2 << code).

Top module: `fifo_word_packer`

## Requirements
- R1: The serial word occupies 1 byte when `word_len_m1` < 8, 2 bytes when it is 8..15, and 4 bytes when it is 16 or more.
- R2: `tx_word` presents the leading bytes of the head transmit entry (byte 0 in [31:24], then [23:16], and so on) right-justified, with zeros above the word. `tx_avail` is high while the transmit queue is not empty.
- R3: A received word is stored right-justified. Bits above its byte width are forced to zero. It is read back from register address 1.
- R4: The status register (address 2) shows live fill state in these bits: 4 transmit not empty, 5 receive not empty, 6 transmit full, 7 receive full.
- R5: A bus write to the transmit queue (address 0) while it is full drops the data and sets error bit 5 (error register, address 4).
- R6: A bus read of the receive queue while it is empty returns zero and sets error bit 4.
- R7: `tx_pop` on an empty transmit queue sets error bit 3. `rx_push` on a full receive queue sets error bit 2, and the word is dropped.
- R8: Error bits stay set until the bus writes 1 to them at address 4. Writing 0 to a bit leaves it unchanged.
- R9: Status bit 10 (bit 11) sets once the transmitted (received) word count reaches the active limit. The limit is the register at address 5 (6) when `use_block` is low and at address 7 (8) when it is high. A limit of 0 never completes. Writing any limit register restarts both counts. The flag stays set until 1 is written to it at address 2.
- R10: Status bit 8 sets when a transmit pop leaves exactly one block of free space. Bit 9 sets when a receive push brings the fill level up to one block. Both are cleared by writing 1 to them.
- R11: `irq` is high when any error bit is set, or when any of status bits 8..11 is set while its bit in the mask register (address 3) is 0.
- R12: With the default codes, each queue holds 8 entries and the block is 4 words.
- R13: After reset, status, error and mask registers read 0, both queues are empty, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at address 1) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| word_len_m1 | input | 5 | Serial word length minus one |
| use_block | input | 1 | Selects block-mode limit registers |
| tx_pop | input | 1 | Engine takes the head transmit word |
| tx_avail | output | 1 | Transmit word available |
| tx_word | output | 32 | Head transmit word, right-justified |
| rx_push | input | 1 | Engine delivers a received word |
| rx_word | input | 32 | Received word, right-justified |
| irq | output | 1 | Service interrupt |

## Verification
The transmit and receive paths are tested at word lengths of 8, 13, 17 and 32 bits. Each length uses entries whose bytes are all different, so a wrong byte lane or a missing zero fill is detected. The queues are then driven past full and past empty, in both directions. This separates data that is correctly dropped from data that is silently accepted, and it confirms that only the matching error bit rises. The count limits are tested in both limit-register modes with a limit that is reached one pop late. This shows whether the inactive register is really ignored and whether done fires on the exact count.

// File: rtl/fwp_pkg.sv
// Shared register addresses, flag positions and geometry helpers for the
// serial word FIFO packer. Assumes a word-addressed register bus.
package fwp_pkg;

    typedef enum logic [3:0] {
        REG_TXQ      = 4'd0,
        REG_RXQ      = 4'd1,
        REG_STAT     = 4'd2,
        REG_SMASK    = 4'd3,
        REG_ERR      = 4'd4,
        REG_FIFO_TXN = 4'd5,
        REG_FIFO_RXN = 4'd6,
        REG_BLK_TXN  = 4'd7,
        REG_BLK_RXN  = 4'd8
    } reg_addr_e;

    // Bit position of the lowest sticky status flag and lowest error flag
    localparam int STAT_LIVE_LO   = 4;
    localparam int STAT_STICKY_LO = 8;
    localparam int ERR_LO         = 2;

    // Block size in words from its 2-bit code
    function automatic int blk_words(input int code);
        return (code == 0) ? 4 : code * 16;
    endfunction

    // Queue depth in words from block and depth codes
    function automatic int queue_words(input int bcode, input int dcode);
        return blk_words(bcode) * (2 << dcode);
    endfunction

    // Bytes per serial word from the word length minus one
    function automatic logic [2:0] lane_bytes(input logic [4:0] len_m1);
        if (len_m1 < 5'd8)       return 3'd1;
        else if (len_m1 < 5'd16) return 3'd2;
        else                     return 3'd4;
    endfunction

endpackage

// File: rtl/fwp_fifo.sv
// Synchronous first-in first-out queue of any depth (not only powers of two).
// A push when full and a pop when empty are ignored; the caller flags them.
module fwp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write, no reset needed for data
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and fill level update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/fwp_align.sv
// Word alignment between 32-bit queue entries and serial words. Transmit
// words are taken from the top bytes of an entry; received words are kept
// right-justified with unused upper bytes cleared.
module fwp_align
    import fwp_pkg::*;
(
    input  logic [4:0]  word_len_m1,
    input  logic [31:0] tx_entry,
    input  logic [31:0] rx_raw,
    output logic [31:0] tx_word,
    output logic [31:0] rx_entry
);
    logic [2:0]  lanes;
    logic [31:0] keep_mask;

    assign lanes = lane_bytes(word_len_m1);

    // Select lane mask and transmit shift by word size
    always_comb begin
        case (lanes)
            3'd1:    begin keep_mask = 32'h0000_00FF; tx_word = {24'h0, tx_entry[31:24]}; end
            3'd2:    begin keep_mask = 32'h0000_FFFF; tx_word = {16'h0, tx_entry[31:16]}; end
            default: begin keep_mask = 32'hFFFF_FFFF; tx_word = tx_entry;                 end
        endcase
    end

    assign rx_entry = rx_raw & keep_mask;
endmodule

// File: rtl/fwp_flags.sv
// Word counters, sticky service/done flags, error flags and interrupt.
// Sets win over same-cycle clears so no event is lost.
module fwp_flags #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 8,
    parameter int BLK   = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_push_ok,
    input  logic             tx_pop_ok,
    input  logic             rx_push_ok,
    input  logic             rx_pop_ok,
    input  logic [LW-1:0]    tx_level,
    input  logic [LW-1:0]    rx_level,
    input  logic [3:0]       err_set,
    input  logic [3:0]       err_clr,
    input  logic [3:0]       svc_clr,
    input  logic             cnt_restart,
    input  logic [CNT_W-1:0] tx_limit,
    input  logic [CNT_W-1:0] rx_limit,
    input  logic [3:0]       svc_mask,
    output logic [3:0]       svc_flags,
    output logic [3:0]       err_flags,
    output logic             irq
);
    logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_next, rx_next;
    logic [3:0]       svc_set;

    assign tx_next = tx_cnt + CNT_W'(1);
    assign rx_next = rx_cnt + CNT_W'(1);

    // Event detection for service and done flags
    always_comb begin
        svc_set[0] = tx_pop_ok && !tx_push_ok && (tx_level == LW'(DEPTH - BLK + 1));
        svc_set[1] = rx_push_ok && !rx_pop_ok && (rx_level == LW'(BLK - 1));
        svc_set[2] = !cnt_restart && tx_pop_ok && (tx_limit != '0) && (tx_next == tx_limit);
        svc_set[3] = !cnt_restart && rx_push_ok && (rx_limit != '0) && (rx_next == rx_limit);
    end

    // Transferred word counters
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_restart) begin
            tx_cnt <= '0;
            rx_cnt <= '0;
        end else begin
            if (tx_pop_ok)  tx_cnt <= tx_next;
            if (rx_push_ok) rx_cnt <= rx_next;
        end
    end

    // Sticky flags with write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_flags <= '0;
            err_flags <= '0;
        end else begin
            svc_flags <= (svc_flags & ~svc_clr) | svc_set;
            err_flags <= (err_flags & ~err_clr) | err_set;
        end
    end

    assign irq = (|err_flags) || (|(svc_flags & ~svc_mask));
endmodule

// File: rtl/fifo_word_packer.sv
// Top of the serial word FIFO packer: register decode for the queues, limit,
// status, mask and error registers; two queues; alignment; flag logic.
// Assumes single-cycle bus strobes and combinational read data.
module fifo_word_packer
    import fwp_pkg::*;
#(
    parameter int BLK_CODE  = 0,
    parameter int FIFO_CODE = 0,
    parameter int CNT_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [4:0]  word_len_m1,
    input  logic        use_block,
    input  logic        tx_pop,
    output logic        tx_avail,
    output logic [31:0] tx_word,
    input  logic        rx_push,
    input  logic [31:0] rx_word,
    output logic        irq
);
    localparam int BLK   = blk_words(BLK_CODE);
    localparam int DEPTH = queue_words(BLK_CODE, FIFO_CODE);
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int NLIM  = 4;

    logic [31:0]      tx_head, rx_head, rx_entry;
    logic [LW-1:0]    tx_level, rx_level;
    logic             tx_empty, out_full, in_empty, in_full;
    logic             wr_txq, rd_rxq, wr_stat, wr_err, wr_mask;
    logic [3:0]       err_set, err_flags, svc_flags, svc_mask;
    logic [CNT_W-1:0] lim_q [NLIM];
    logic [NLIM-1:0]  lim_we;
    logic [CNT_W-1:0] tx_limit, rx_limit;

    assign wr_txq  = bus_wr && (bus_addr == REG_TXQ);
    assign rd_rxq  = bus_rd && (bus_addr == REG_RXQ);
    assign wr_stat = bus_wr && (bus_addr == REG_STAT);
    assign wr_err  = bus_wr && (bus_addr == REG_ERR);
    assign wr_mask = bus_wr && (bus_addr == REG_SMASK);

    fwp_fifo #(.W(32), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_txq), .push_data(bus_wdata),
        .pop(tx_pop), .head(tx_head), .level(tx_level), .empty(tx_empty), .full(out_full)
    );

    fwp_fifo #(.W(32), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_entry),
        .pop(rd_rxq), .head(rx_head), .level(rx_level), .empty(in_empty), .full(in_full)
    );

    fwp_align u_align (
        .word_len_m1(word_len_m1), .tx_entry(tx_head), .rx_raw(rx_word),
        .tx_word(tx_word), .rx_entry(rx_entry)
    );

    assign tx_avail = !tx_empty;

    // Error events: [0] rx overrun, [1] tx underrun, [2] rx underrun, [3] tx overrun
    assign err_set = {wr_txq && out_full, rd_rxq && in_empty,
                      tx_pop && tx_empty, rx_push && in_full};

    // Four limit registers, addresses 5..8 in order
    genvar gi;
    generate
        for (gi = 0; gi < NLIM; gi++) begin : g_lim
            assign lim_we[gi] = bus_wr && (bus_addr == 4'(int'(REG_FIFO_TXN) + gi));
            // Hold one limit register
            always_ff @(posedge clk) begin
                if (!rst_n)          lim_q[gi] <= '0;
                else if (lim_we[gi]) lim_q[gi] <= bus_wdata[CNT_W-1:0];
            end
        end
    endgenerate

    assign tx_limit = use_block ? lim_q[2] : lim_q[0];
    assign rx_limit = use_block ? lim_q[3] : lim_q[1];

    // Interrupt mask for sticky status flags
    always_ff @(posedge clk) begin
        if (!rst_n)       svc_mask <= '0;
        else if (wr_mask) svc_mask <= bus_wdata[STAT_STICKY_LO +: 4];
    end

    fwp_flags #(.CNT_W(CNT_W), .DEPTH(DEPTH), .BLK(BLK)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .tx_push_ok(wr_txq && !out_full), .tx_pop_ok(tx_pop && !tx_empty),
        .rx_push_ok(rx_push && !in_full), .rx_pop_ok(rd_rxq && !in_empty),
        .tx_level(tx_level), .rx_level(rx_level),
        .err_set(err_set),
        .err_clr(wr_err ? bus_wdata[ERR_LO +: 4] : 4'h0),
        .svc_clr(wr_stat ? bus_wdata[STAT_STICKY_LO +: 4] : 4'h0),
        .cnt_restart(|lim_we),
        .tx_limit(tx_limit), .rx_limit(rx_limit),
        .svc_mask(svc_mask), .svc_flags(svc_flags), .err_flags(err_flags), .irq(irq)
    );

    // Register read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_RXQ:      bus_rdata = in_empty ? 32'h0 : rx_head;
            REG_STAT:     bus_rdata = {20'h0, svc_flags, in_full, out_full, !in_empty, !tx_empty, 4'h0};
            REG_SMASK:    bus_rdata = {20'h0, svc_mask, 8'h0};
            REG_ERR:      bus_rdata = {26'h0, err_flags, 2'b00};
            REG_FIFO_TXN: bus_rdata = 32'(lim_q[0]);
            REG_FIFO_RXN: bus_rdata = 32'(lim_q[1]);
            REG_BLK_TXN:  bus_rdata = 32'(lim_q[2]);
            REG_BLK_RXN:  bus_rdata = 32'(lim_q[3]);
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fwp_checker.sv
// Property checker for fifo_word_packer, attached by bind below.
module fwp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        rx_push,
    input logic        irq,
    input logic        out_full,
    input logic        in_full,
    input logic        in_empty,
    input logic [3:0]  err_flags,
    input logic [3:0]  svc_flags
);
    assert_tx_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd0 && out_full) |=> err_flags[3]);

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'd1 && in_empty) |-> (bus_rdata == 32'h0));

    assert_rx_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !in_full) |=> !in_empty);

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_flags[2] && !(bus_wr && bus_addr == 4'd2 && bus_wdata[10])) |=> svc_flags[2]);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags[0] && !(bus_wr && bus_addr == 4'd4 && bus_wdata[2])) |=> err_flags[0]);

    assert_irq_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !irq);
endmodule

bind fifo_word_packer fwp_checker u_fwp_checker (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_push(rx_push), .irq(irq),
    .out_full(out_full), .in_full(in_full), .in_empty(in_empty),
    .err_flags(err_flags), .svc_flags(svc_flags)
);

// File: tb/fifo_word_packer_bench.sv
module fifo_word_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  word_len_m1 = 5'd7;
    logic        use_block = 1'b0;
    logic        tx_pop = 1'b0;
    logic        tx_avail;
    logic [31:0] tx_word;
    logic        rx_push = 1'b0;
    logic [31:0] rx_word = '0;
    logic        irq;

    int compared = 0, mismatched = 0;
    bit finished = 0;
    logic [31:0] exp_tx [$];
    logic [31:0] exp_rx [$];

    always #5 clk = ~clk;

    fifo_word_packer u_fifo_word_packer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .word_len_m1(word_len_m1),
        .use_block(use_block), .tx_pop(tx_pop), .tx_avail(tx_avail), .tx_word(tx_word),
        .rx_push(rx_push), .rx_word(rx_word), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    // Driver: write a transmit entry and queue its expected serial word
    task automatic send(input logic [31:0] entry, input logic [31:0] word, input bit keep);
        bus_write(4'd0, entry);
        if (keep) exp_tx.push_back(word);
    endtask

    // Monitor: engine pops one word and compares with the scoreboard
    task automatic take(input string req);
        logic [31:0] got, exp;
        @(negedge clk); tx_pop = 1'b1;
        #1 got = tx_word;
        @(negedge clk); tx_pop = 1'b0;
        exp = (exp_tx.size() > 0) ? exp_tx.pop_front() : 32'hXXXX_XXXX;
        check(req, got, exp);
    endtask

    task automatic deliver(input logic [31:0] raw, input logic [31:0] stored, input bit keep);
        @(negedge clk); rx_push = 1'b1; rx_word = raw;
        @(negedge clk); rx_push = 1'b0;
        if (keep) exp_rx.push_back(stored);
    endtask

    task automatic collect(input string req);
        logic [31:0] d;
        bus_read(4'd1, d);
        check(req, d, (exp_rx.size() > 0) ? exp_rx.pop_front() : 32'hXXXX_XXXX);
    endtask

    task automatic check_irq(input string req, input logic exp);
        @(negedge clk); #1 check(req, {31'h0, irq}, {31'h0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        expect_reg("R13 status", 4'd2, 32'h0);
        expect_reg("R13 errors", 4'd4, 32'h0);
        expect_reg("R13 mask", 4'd3, 32'h0);
        check_irq("R13 irq", 1'b0);

        // R2 / R1 one-byte words from the top lane
        word_len_m1 = 5'd7;
        send(32'hA1B2C3D4, 32'hA1, 1);
        send(32'h55667788, 32'h55, 1);
        send(32'h0F000000, 32'h0F, 1);
        expect_reg("R4 tx not empty", 4'd2, 32'h010);
        check_irq("R11 irq idle", 1'b0);
        repeat (3) take("R2 byte word");
        word_len_m1 = 5'd12;
        send(32'h1234ABCD, 32'h1234, 1);
        take("R1 two-byte word");
        word_len_m1 = 5'd16;
        send(32'h01020304, 32'h01020304, 1);
        take("R1 17-bit uses four bytes");
        word_len_m1 = 5'd31;
        send(32'hCAFEF00D, 32'hCAFEF00D, 1);
        take("R2 full word");
        expect_reg("R4 drained", 4'd2, 32'h0);

        // R3 right-justified receive
        word_len_m1 = 5'd7;
        deliver(32'hDEADBEEF, 32'h000000EF, 1);
        expect_reg("R4 rx not empty", 4'd2, 32'h020);
        collect("R3 byte word");
        word_len_m1 = 5'd9;
        deliver(32'hDEADBEEF, 32'h0000BEEF, 1);
        collect("R3 two-byte word");
        word_len_m1 = 5'd20;
        deliver(32'hDEADBEEF, 32'hDEADBEEF, 1);
        collect("R3 four-byte word");

        // R12 / R5 / R10 / R7 transmit overflow and drain
        word_len_m1 = 5'd31;
        for (int i = 0; i < 9; i++) send(32'h10000000 + i, 32'h10000000 + i, i < 8);
        expect_reg("R12 tx full after 8", 4'd2, 32'h050);
        expect_reg("R5 tx overrun", 4'd4, 32'h20);
        for (int i = 0; i < 8; i++) take("R5 kept entries");
        expect_reg("R10 tx service", 4'd2, 32'h100);
        @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        expect_reg("R7 tx underrun", 4'd4, 32'h28);
        check_irq("R11 irq on errors", 1'b1);

        // R8 selective clear, R11 masking
        bus_write(4'd4, 32'h20);
        expect_reg("R8 partial clear", 4'd4, 32'h08);
        bus_write(4'd4, 32'h08);
        expect_reg("R8 full clear", 4'd4, 32'h0);
        check_irq("R11 unmasked service", 1'b1);
        bus_write(4'd3, 32'h100);
        check_irq("R11 masked service", 1'b0);
        bus_write(4'd2, 32'h100);
        bus_write(4'd3, 32'h0);
        expect_reg("R10 service cleared", 4'd2, 32'h0);

        // R6 empty receive read
        expect_reg("R6 empty read zero", 4'd1, 32'h0);
        expect_reg("R6 rx underrun", 4'd4, 32'h10);
        bus_write(4'd4, 32'h10);

        // R7 receive overflow, R10 receive service
        for (int i = 0; i < 9; i++) deliver(32'h20000000 + i, 32'h20000000 + i, i < 8);
        expect_reg("R10 R12 rx full and service", 4'd2, 32'h2A0);
        expect_reg("R7 rx overrun", 4'd4, 32'h04);
        for (int i = 0; i < 8; i++) collect("R7 kept rx entries");
        expect_reg("R7 rx empty after drain", 4'd2, 32'h200);
        bus_write(4'd4, 32'h04);
        bus_write(4'd2, 32'h200);
        check_irq("R11 irq clear", 1'b0);

        // R9 FIFO-mode limits
        bus_write(4'd5, 32'd3);
        for (int i = 0; i < 3; i++) send(32'h30000000 + i, 32'h30000000 + i, 1);
        take("R9 tx data"); take("R9 tx data");
        expect_reg("R9 not yet done", 4'd2, 32'h010);
        take("R9 tx data");
        expect_reg("R9 tx done", 4'd2, 32'h400);
        bus_write(4'd2, 32'h400);
        bus_write(4'd6, 32'd2);
        deliver(32'h41, 32'h41, 1);
        deliver(32'h42, 32'h42, 1);
        expect_reg("R9 rx done", 4'd2, 32'h820);
        collect("R9 rx data"); collect("R9 rx data");
        bus_write(4'd2, 32'h800);

        // R9 block-mode limits ignore the FIFO-mode register
        use_block = 1'b1;
        bus_write(4'd5, 32'd1);
        bus_write(4'd7, 32'd2);
        send(32'h50000000, 32'h50000000, 1);
        send(32'h50000001, 32'h50000001, 1);
        take("R9 block data");
        expect_reg("R9 block limit not reached", 4'd2, 32'h010);
        take("R9 block data");
        expect_reg("R9 block tx done", 4'd2, 32'h400);
        bus_write(4'd2, 32'h400);
        expect_reg("R9 done cleared", 4'd2, 32'h0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule